// File: doc/BRIEF.md
# Scanline Triangle Rasterizer with Slope Setup

This block turns one screen-space triangle into the stream of pixels it covers. A triangle enters as three vertices, each with a 12-bit X and a 12-bit Y, through a valid/ready handshake. The block first orders the vertices by Y. It then derives the three edge slopes (change in X per row) by multiplying each X difference by a reciprocal of the Y difference. The reciprocal comes from a lookup table, so no divider is needed.

After setup, the block walks rows upward, from the lowest vertex to the highest. Within each row it moves left to right. It emits each covered pixel as X, Y and a linear buffer index, through a second valid/ready handshake. The index is the address that a following depth-test or shading stage would use for its frame and depth buffers. When the last pixel has been taken, a one-cycle done pulse marks the end of the triangle, and the block is ready for the next one.

Vertex X values must stay below 2048. The triangle's height must be smaller than the reciprocal table depth (default 1024 rows). The viewport width must be held steady while a triangle is in flight.

Top module: `tri_raster`

## Requirements
- R1: The reciprocal of a Y difference d is 0 for d = 0, 0x7FFF for d = 1, and floor(32768 / d) for d ≥ 2. It is an unsigned value with 1 integer bit and 15 fraction bits.
- R2: Each edge slope is (Xend − Xstart) × recip(Yend − Ystart), kept as a signed 27-bit value with 15 fraction bits. Each edge position starts at its start vertex X shifted left by 15. On each new row, the slope is added to the position. The pixel column used for a row is the position shifted right arithmetically by 15 (floor).
- R3: The vertices are ordered low, middle and high by Y; equal Y values keep the input order a, b, c. Rows run from the low Y to the high Y, stepping by +1, and each row is emitted exactly once.
- R4: Each row emits every X from the smaller to the larger of the two edge columns, both ends included, in increasing X order. One edge is the long edge (low to high); the other is the short edge.
- R5: Below the middle row, the short edge runs from the low vertex with the low-to-middle slope. On the middle vertex's row, the short edge restarts at exactly the middle X and then follows the middle-to-high slope.
- R6: When the low and middle vertices share a Y, the lower part is skipped. The short edge starts at the middle X on the first row and uses the middle-to-high slope.
- R7: When all three Y values are equal, exactly one row is emitted, spanning from the minimum to the maximum of the three X values.
- R8: `pix_idx` equals `pix_y` × `vp_width` + `pix_x`, as a 24-bit value.
- R9: While `pix_valid` is high and `pix_ready` is low, `pix_valid`, `pix_x`, `pix_y` and `pix_idx` hold their values.
- R10: A triangle is taken on a cycle where `tri_valid` and `tri_ready` are both high, and `tri_ready` then stays low until the triangle is finished. `done` is high for exactly one cycle, right after the last pixel transfer. `tri_ready` returns high on the following cycle.
- R11: After reset, `tri_ready` is high and both `pix_valid` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tri_valid | input | 1 | Triangle vertices are presented |
| tri_ready | output | 1 | Block is idle and will take a triangle |
| ax | input | 12 | Vertex a, X |
| ay | input | 12 | Vertex a, Y |
| bx | input | 12 | Vertex b, X |
| by | input | 12 | Vertex b, Y |
| cx | input | 12 | Vertex c, X |
| cy | input | 12 | Vertex c, Y |
| vp_width | input | 12 | Viewport width in pixels, used for the index |
| pix_valid | output | 1 | A pixel is presented |
| pix_ready | input | 1 | Consumer takes the presented pixel |
| pix_x | output | 12 | Pixel column |
| pix_y | output | 12 | Pixel row |
| pix_idx | output | 24 | Linear buffer address of the pixel |
| done | output | 1 | One-cycle pulse after the triangle's last pixel |

## Verification
A wrong vertex order or a bad slope shows up on the very first row as a wrong span start or end. A wrong accumulator update shows up a few rows later as a column drifting by one. A missed restart at the middle vertex shows up as a bent upper edge from the middle row onward. Comparing every emitted pixel, in order, against a fixed-point model catches each of these at the first pixel that differs. The random back-pressure on `pix_ready` exposes any output that changes while stalled. The count of pixels before `done` exposes rows that are dropped or repeated.

// File: rtl/tri_raster_pkg.sv
package tri_raster_pkg;

    localparam int CW   = 12;
    localparam int FRAC = 15;
    localparam int RW   = 16;
    localparam int SW   = 27;
    localparam int ACCW = CW + FRAC + 2;
    localparam int PXW  = ACCW - FRAC;
    localparam int IDXW = 2 * CW;

    typedef logic [CW-1:0] coord_t;

    typedef struct packed {
        coord_t x;
        coord_t y;
    } vtx_t;

    typedef enum logic [2:0] {
        ST_IDLE, ST_SORT, ST_SLOPE, ST_INIT, ST_ROW, ST_SPAN, ST_STEP, ST_DONE
    } st_t;

    function automatic logic [RW-1:0] recip_val(input int unsigned d);
        int unsigned q;
        if (d == 0)
            q = 0;
        else if (d == 1)
            q = 32'h7FFF;
        else
            q = 32'd32768 / d;
        return q[RW-1:0];
    endfunction

    function automatic logic signed [ACCW-1:0] to_fix(input coord_t c);
        return $signed({{(ACCW-CW-FRAC){1'b0}}, c, {FRAC{1'b0}}});
    endfunction

    function automatic logic signed [PXW-1:0] px_of(input logic signed [ACCW-1:0] a);
        return a[ACCW-1:FRAC];
    endfunction

    function automatic coord_t min3(input coord_t a, input coord_t b, input coord_t c);
        coord_t m;
        m = (a < b) ? a : b;
        return (c < m) ? c : m;
    endfunction

    function automatic coord_t max3(input coord_t a, input coord_t b, input coord_t c);
        coord_t m;
        m = (a > b) ? a : b;
        return (c > m) ? c : m;
    endfunction

endpackage

// File: rtl/tri_recip_rom.sv
module tri_recip_rom
    import tri_raster_pkg::*;
#(
    parameter int DEPTH = 1024
) (
    input  coord_t          dy,
    output logic [RW-1:0]   rval
);
    localparam int AW = $clog2(DEPTH);

    logic [RW-1:0] tbl [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        assign tbl[i] = recip_val(i);
    end

    always_comb begin
        if (32'(dy) < DEPTH)
            rval = tbl[dy[AW-1:0]];
        else
            rval = '0;
    end
endmodule

// File: rtl/tri_vsort.sv
module tri_vsort
    import tri_raster_pkg::*;
(
    input  vtx_t v0,
    input  vtx_t v1,
    input  vtx_t v2,
    output vtx_t lo,
    output vtx_t mid,
    output vtx_t hi
);
    logic signed [CW:0] d01, d02, d12;

    always_comb begin
        d01 = $signed({1'b0, v1.y}) - $signed({1'b0, v0.y});
        d02 = $signed({1'b0, v2.y}) - $signed({1'b0, v0.y});
        d12 = $signed({1'b0, v2.y}) - $signed({1'b0, v1.y});
        case ({d01[CW], d02[CW], d12[CW]})
            3'b001:  begin lo = v0; mid = v2; hi = v1; end
            3'b011:  begin lo = v2; mid = v0; hi = v1; end
            3'b100:  begin lo = v1; mid = v0; hi = v2; end
            3'b110:  begin lo = v1; mid = v2; hi = v0; end
            3'b111:  begin lo = v2; mid = v1; hi = v0; end
            default: begin lo = v0; mid = v1; hi = v2; end
        endcase
    end
endmodule

// File: rtl/tri_slope_mul.sv
module tri_slope_mul
    import tri_raster_pkg::*;
(
    input  coord_t                 xa,
    input  coord_t                 xb,
    input  logic [RW-1:0]          rval,
    output logic signed [SW-1:0]   slope
);
    logic signed [CW:0]        dx;
    logic signed [CW+RW+1:0]   prod;

    always_comb begin
        dx    = $signed({1'b0, xb}) - $signed({1'b0, xa});
        prod  = dx * $signed({1'b0, rval});
        slope = prod[SW-1:0];
    end
endmodule

// File: rtl/tri_raster.sv
module tri_raster
    import tri_raster_pkg::*;
#(
    parameter int RECIP_DEPTH = 1024
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tri_valid,
    output logic              tri_ready,
    input  logic [CW-1:0]     ax,
    input  logic [CW-1:0]     ay,
    input  logic [CW-1:0]     bx,
    input  logic [CW-1:0]     by,
    input  logic [CW-1:0]     cx,
    input  logic [CW-1:0]     cy,
    input  logic [CW-1:0]     vp_width,
    output logic              pix_valid,
    input  logic              pix_ready,
    output logic [CW-1:0]     pix_x,
    output logic [CW-1:0]     pix_y,
    output logic [IDXW-1:0]   pix_idx,
    output logic              done
);
    st_t st;
    vtx_t va, vb, vc;
    vtx_t lo, mid, hi;
    vtx_t s_lo, s_mid, s_hi;
    logic [1:0] ek;
    logic signed [SW-1:0] slope_l, slope_a, slope_b, sl;
    logic signed [ACCW-1:0] acc_l, acc_s;
    logic upper;
    coord_t cur_x, cur_y, x_end, ny;
    coord_t mx_a, mx_b, my_a, my_b, dy;
    logic [RW-1:0] rv;
    logic signed [PXW-1:0] pl, ps, row_lo, row_hi;

    tri_vsort u_sort (
        .v0(va), .v1(vb), .v2(vc),
        .lo(s_lo), .mid(s_mid), .hi(s_hi)
    );

    always_comb begin
        case (ek)
            2'd0:    begin mx_a = lo.x;  mx_b = hi.x;  my_a = lo.y;  my_b = hi.y;  end
            2'd1:    begin mx_a = lo.x;  mx_b = mid.x; my_a = lo.y;  my_b = mid.y; end
            default: begin mx_a = mid.x; mx_b = hi.x;  my_a = mid.y; my_b = hi.y;  end
        endcase
        dy = my_b - my_a;
    end

    tri_recip_rom #(.DEPTH(RECIP_DEPTH)) u_rom (
        .dy(dy), .rval(rv)
    );

    tri_slope_mul u_mul (
        .xa(mx_a), .xb(mx_b), .rval(rv), .slope(sl)
    );

    always_comb begin
        pl     = px_of(acc_l);
        ps     = px_of(acc_s);
        row_lo = (pl < ps) ? pl : ps;
        row_hi = (pl < ps) ? ps : pl;
        ny     = cur_y + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            va      <= '0;
            vb      <= '0;
            vc      <= '0;
            lo      <= '0;
            mid     <= '0;
            hi      <= '0;
            ek      <= '0;
            slope_l <= '0;
            slope_a <= '0;
            slope_b <= '0;
            acc_l   <= '0;
            acc_s   <= '0;
            upper   <= 1'b0;
            cur_x   <= '0;
            cur_y   <= '0;
            x_end   <= '0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (tri_valid) begin
                        va <= '{x: ax, y: ay};
                        vb <= '{x: bx, y: by};
                        vc <= '{x: cx, y: cy};
                        st <= ST_SORT;
                    end
                end
                ST_SORT: begin
                    lo  <= s_lo;
                    mid <= s_mid;
                    hi  <= s_hi;
                    ek  <= 2'd0;
                    st  <= ST_SLOPE;
                end
                ST_SLOPE: begin
                    case (ek)
                        2'd0:    slope_l <= sl;
                        2'd1:    slope_a <= sl;
                        default: slope_b <= sl;
                    endcase
                    if (ek == 2'd2)
                        st <= ST_INIT;
                    ek <= ek + 2'd1;
                end
                ST_INIT: begin
                    acc_l <= to_fix(lo.x);
                    cur_y <= lo.y;
                    if (lo.y == hi.y) begin
                        cur_x <= min3(lo.x, mid.x, hi.x);
                        x_end <= max3(lo.x, mid.x, hi.x);
                        st    <= ST_SPAN;
                    end else if (mid.y == lo.y) begin
                        acc_s <= to_fix(mid.x);
                        upper <= 1'b1;
                        st    <= ST_ROW;
                    end else begin
                        acc_s <= to_fix(lo.x);
                        upper <= 1'b0;
                        st    <= ST_ROW;
                    end
                end
                ST_ROW: begin
                    cur_x <= row_lo[CW-1:0];
                    x_end <= row_hi[CW-1:0];
                    st    <= ST_SPAN;
                end
                ST_SPAN: begin
                    if (pix_ready) begin
                        if (cur_x == x_end)
                            st <= (cur_y == hi.y) ? ST_DONE : ST_STEP;
                        else
                            cur_x <= cur_x + 1'b1;
                    end
                end
                ST_STEP: begin
                    cur_y <= ny;
                    acc_l <= acc_l + slope_l;
                    if (ny == mid.y) begin
                        acc_s <= to_fix(mid.x);
                        upper <= 1'b1;
                    end else begin
                        acc_s <= acc_s + (upper ? slope_b : slope_a);
                    end
                    st <= ST_ROW;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign tri_ready = (st == ST_IDLE);
    assign pix_valid = (st == ST_SPAN);
    assign done      = (st == ST_DONE);
    assign pix_x     = cur_x;
    assign pix_y     = cur_y;
    assign pix_idx   = IDXW'(cur_y) * IDXW'(vp_width) + IDXW'(cur_x);

endmodule

// File: rtl/tri_raster_chk.sv
module tri_raster_chk
    import tri_raster_pkg::*;
(
    input logic   clk,
    input logic   rst,
    input logic   tri_valid,
    input logic   tri_ready,
    input logic   pix_valid,
    input logic   pix_ready,
    input coord_t pix_x,
    input coord_t pix_y,
    input logic   done
);
    // R9
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (pix_valid && !pix_ready) |=> (pix_valid && $stable(pix_x) && $stable(pix_y)));

    // R4
    span_step_chk: assert property (@(posedge clk) disable iff (rst)
        (pix_valid && pix_ready) |=>
            (!pix_valid || (pix_y != $past(pix_y)) || (pix_x == $past(pix_x) + 1'b1)));

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R10
    done_after_xfer_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> $past(pix_valid && pix_ready));

    // R10
    accept_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (tri_valid && tri_ready) |=> !tri_ready);
endmodule

bind tri_raster tri_raster_chk u_chk (
    .clk(clk), .rst(rst), .tri_valid(tri_valid), .tri_ready(tri_ready),
    .pix_valid(pix_valid), .pix_ready(pix_ready),
    .pix_x(pix_x), .pix_y(pix_y), .done(done)
);

// File: tb/tri_raster_test.sv
module tri_raster_test;
    import tri_raster_pkg::*;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst, tri_valid, tri_ready, pix_valid, pix_ready, done;
    logic [CW-1:0] ax, ay, bx, by, cx, cy, vp_width, pix_x, pix_y;
    logic [IDXW-1:0] pix_idx;

    int total = 0;
    int bad = 0;
    bit finished = 0;
    int q[$];

    tri_raster uut (
        .clk(clk), .rst(rst), .tri_valid(tri_valid), .tri_ready(tri_ready),
        .ax(ax), .ay(ay), .bx(bx), .by(by), .cx(cx), .cy(cy),
        .vp_width(vp_width), .pix_valid(pix_valid), .pix_ready(pix_ready),
        .pix_x(pix_x), .pix_y(pix_y), .pix_idx(pix_idx), .done(done)
    );

    task automatic chk(input bit ok, input string msg);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s", msg);
        end
    endtask

    // R1 reciprocal model
    function automatic int rcp(input int d);
        if (d == 0) return 0;
        if (d == 1) return 32'h7FFF;
        return 32768 / d;
    endfunction

    // R2..R7 expected pixel order
    task automatic gen(input int x0, input int y0, input int x1, input int y1,
                       input int x2, input int y2);
        int xs[3], ys[3];
        int t, xl, yl, xm, ym, xh, yh, sl, sa, sb, al, as, up, y, pl, ps, a, b;
        xs[0] = x0; xs[1] = x1; xs[2] = x2;
        ys[0] = y0; ys[1] = y1; ys[2] = y2;
        for (int p = 0; p < 2; p++)
            for (int k = 0; k < 2 - p; k++)
                if (ys[k] > ys[k+1]) begin
                    t = ys[k]; ys[k] = ys[k+1]; ys[k+1] = t;
                    t = xs[k]; xs[k] = xs[k+1]; xs[k+1] = t;
                end
        xl = xs[0]; yl = ys[0]; xm = xs[1]; ym = ys[1]; xh = xs[2]; yh = ys[2];
        q.delete();
        if (yl == yh) begin
            a = xl; b = xl;
            for (int k = 0; k < 3; k++) begin
                if (xs[k] < a) a = xs[k];
                if (xs[k] > b) b = xs[k];
            end
            for (int x = a; x <= b; x++) q.push_back((x << 16) | yl);
            return;
        end
        sl = (xh - xl) * rcp(yh - yl);
        sa = (xm - xl) * rcp(ym - yl);
        sb = (xh - xm) * rcp(yh - ym);
        al = xl << 15;
        if (ym == yl) begin as = xm << 15; up = 1; end
        else begin as = xl << 15; up = 0; end
        y = yl;
        while (1) begin
            pl = al >>> 15;
            ps = as >>> 15;
            a = (pl < ps) ? pl : ps;
            b = (pl < ps) ? ps : pl;
            for (int x = a; x <= b; x++) q.push_back((x << 16) | y);
            if (y == yh) break;
            al += sl;
            if (y + 1 == ym) begin as = xm << 15; up = 1; end
            else as += (up != 0) ? sb : sa;
            y++;
        end
    endtask

    task automatic run_tri(input int x0, input int y0, input int x1, input int y1,
                           input int x2, input int y2, input int w, input string tag);
        int e, ex, ey, cnt;
        bit hold_p;
        logic [CW-1:0] hx, hy;
        logic [IDXW-1:0] hidx;
        gen(x0, y0, x1, y1, x2, y2);
        cnt = q.size();
        @(negedge clk);
        vp_width = CW'(w);
        ax = CW'(x0); ay = CW'(y0); bx = CW'(x1); by = CW'(y1); cx = CW'(x2); cy = CW'(y2);
        tri_valid = 1'b1;
        while (!tri_ready) @(negedge clk);
        @(negedge clk);
        tri_valid = 1'b0;
        hold_p = 0;
        hx = '0; hy = '0; hidx = '0;
        while (1) begin
            @(negedge clk);
            if (done) begin
                chk(q.size() == 0, $sformatf("R10 %s done with %0d pixels left, expected 0 (of %0d)",
                                             tag, q.size(), cnt));
                break;
            end
            if (hold_p)
                chk(pix_valid && pix_x == hx && pix_y == hy && pix_idx == hidx,
                    $sformatf("R9 held pixel changed: got v=%0b (%0d,%0d,%0d) expected (%0d,%0d,%0d)",
                              pix_valid, pix_x, pix_y, pix_idx, hx, hy, hidx));
            pix_ready = ($urandom % 4) != 0;
            if (pix_valid && pix_ready) begin
                if (q.size() == 0) begin
                    chk(0, $sformatf("R3 %s extra pixel (%0d,%0d), expected none", tag, pix_x, pix_y));
                end else begin
                    e = q.pop_front();
                    ex = e >>> 16;
                    ey = e & 32'hFFFF;
                    chk(int'(pix_x) == ex && int'(pix_y) == ey,
                        $sformatf("%s pixel got (%0d,%0d) expected (%0d,%0d)", tag, pix_x, pix_y, ex, ey));
                    chk(int'(pix_idx) == ey * w + ex,
                        $sformatf("R8 index got %0d expected %0d", pix_idx, ey * w + ex));
                end
            end
            hold_p = pix_valid && !pix_ready;
            hx = pix_x; hy = pix_y; hidx = pix_idx;
        end
        @(negedge clk);
        chk(tri_ready && !done, $sformatf("R10 after done: ready=%0b done=%0b expected 1,0", tri_ready, done));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL R10 watchdog expired: run did not finish, expected completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240));
        rst = 1'b1; tri_valid = 1'b0; pix_ready = 1'b0; vp_width = 12'd320;
        ax = '0; ay = '0; bx = '0; by = '0; cx = '0; cy = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11
        chk(tri_ready && !pix_valid && !done,
            $sformatf("R11 reset state ready=%0b valid=%0b done=%0b expected 1,0,0",
                      tri_ready, pix_valid, done));

        run_tri(10, 5, 30, 5, 20, 15, 320, "R6 flat bottom");
        run_tri(30, 5, 10, 5, 20, 15, 320, "R6 R3 flat bottom swapped");
        run_tri(5, 2, 25, 12, 8, 12, 320, "R5 flat top");
        run_tri(40, 7, 3, 7, 22, 7, 320, "R7 all rows equal");
        run_tri(9, 9, 9, 9, 9, 9, 320, "R7 single point");
        run_tri(0, 0, 40, 1, 20, 2, 320, "R1 R2 unit height edges");
        run_tri(5, 0, 50, 20, 30, 35, 320, "R2 R3 R4 R5 split");
        run_tri(50, 30, 2, 4, 60, 17, 97, "R8 R4 narrow viewport");
        run_tri(20, 0, 21, 40, 19, 39, 200, "R1 R2 steep sliver");

        for (int n = 0; n < 40; n++) begin
            int r[6];
            for (int k = 0; k < 6; k++) r[k] = (k % 2 == 0) ? int'($urandom % 64) : int'($urandom % 48);
            run_tri(r[0], r[1], r[2], r[3], r[4], r[5], 64 + int'($urandom % 448),
                    "R2 R3 R4 R5 random");
        end

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule